// File: doc/BRIEF.md
# Octave Split Filter Stage

This block is a single octave of a cascaded filter bank. Signed 16-bit samples arrive with a valid strobe. A 3-tap low-pass with weights 1/4, 1/2 and 1/4 smooths them, and every second accepted sample the smoothed value leaves the block as a half-rate output for the next, lower octave. The same smoothed value is also subtracted from the input sample taken three samples earlier. That difference holds the upper half of the octave. A 7-tap symmetric FIR, built only from shifts and adds, shapes it into a band-pass output at the full input rate.

A band pseudo-power figure is formed by summing the magnitude of the band-pass output over a window of 2^N samples and dividing by the window length. N is programmable. A synchronous clear empties all history, restarts the decimation phase and drops any partial power window. Every output is registered and appears on the clock edge that accepts the sample producing it.

Top module: `octave_split_stage`

## Requirements
- R1: After reset or after a cycle with `clr` high, the following hold. All valid outputs are low and all data outputs read 0. Sample history reads as zero. The next accepted sample is counted as the first for decimation and for the power window. A sample presented together with `clr` is ignored.
- R2: For each accepted sample x[n], the smoothed value is f[n] = floor((x[n] + 2*x[n-1] + x[n-2] + 2) / 4). On the 2nd, 4th, 6th and later even-numbered accepted samples, `lp_valid` is high in the following cycle with `lp_data` = f[n]. On all other cycles `lp_valid` is low.
- R3: The band difference is d[n] = x[n-3] - f[n], carried at 18 bits without wrap.
- R4: With the default taps c = (-1/16, 1/8, -1/4, 1/2, -1/4, 1/8, -1/16), where c0 weights d[n], the band-pass result is bp[n] = floor((16*sum_k c_k*d[n-k] + 8) / 16). It appears on `bp_data` with `bp_valid` high in the cycle after each accepted sample.
- R5: The band-pass result saturates to the range [-32768, 32767] instead of wrapping.
- R6: `pwr_data` is the sum of |bp| over the 2^N band-pass outputs of a window, shifted right by N. `pwr_valid` is high in the same cycle as the `bp_valid` of the window's last sample.
- R7: `avg_log2` values below 2 act as N = 2, and values above 8 act as N = 8.
- R8: N is taken from `avg_log2` at the first sample of each window. A change to `avg_log2` part-way through a window has no effect until the next window.
- R9: Cycles without an accepted sample produce no valid output and leave `lp_data` and all history unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of history, phase and power window |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| avg_log2 | input | 4 | Power window exponent N (clamped to 2..8) |
| lp_valid | output | 1 | Decimated low-pass output strobe |
| lp_data | output | 16 | Signed decimated low-pass sample |
| bp_valid | output | 1 | Band-pass output strobe |
| bp_data | output | 16 | Signed band-pass sample |
| pwr_valid | output | 1 | Pseudo-power output strobe |
| pwr_data | output | 16 | Unsigned mean band magnitude |

## Verification
The assertions assume three things about the inputs. `in_valid` and `clr` are driven to known levels from the first clock edge onward. `clr` only clears, so a sample presented together with it never reaches the strobes. `avg_log2` may hold any 4-bit value at any time, because the design clamps it and only samples it at a window start. The stimulus drives every input between clock edges from time zero. It presents samples either back to back or separated by idle gaps. It raises `clr` only as an isolated pulse, and it deliberately places out-of-range and mid-window changes on `avg_log2` so that the clamping and latching are exercised.

// File: rtl/osf_pkg.sv
package osf_pkg;
  localparam int SW       = 16;
  localparam int DW       = SW + 2;
  localparam int FRAC_MAX = 8;
  localparam int ACC_W    = DW + FRAC_MAX + 3;

  typedef logic signed [SW-1:0]  sample_t;
  typedef logic signed [DW-1:0]  diff_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [SW:0]           mag_t;

  localparam acc_t SAT_HI = acc_t'((2 ** (SW - 1)) - 1);
  localparam acc_t SAT_LO = acc_t'(-(2 ** (SW - 1)));

  // quarter-half-quarter smoothing with round-half-up
  function automatic sample_t lp3(sample_t a, sample_t b, sample_t c);
    logic signed [SW+1:0] ea, eb, ec, s;
    ea = a;
    eb = b;
    ec = c;
    s  = ea + (eb <<< 1) + ec + (SW+2)'(2);
    return sample_t'(s >>> 2);
  endfunction

  // drop frac fraction bits with rounding, then clamp to sample range
  function automatic sample_t sat_round(acc_t s, int unsigned frac);
    acc_t r;
    r = (s + (acc_t'(1) <<< (frac - 1))) >>> frac;
    if (r > SAT_HI) return sample_t'(SAT_HI);
    if (r < SAT_LO) return sample_t'(SAT_LO);
    return sample_t'(r);
  endfunction

  function automatic mag_t mag(sample_t v);
    logic signed [SW:0] e;
    e = v;
    if (e < 0) e = -e;
    return mag_t'(e);
  endfunction
endpackage

// File: rtl/osf_lowpass.sv
module osf_lowpass
  import osf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    in_valid,
  input  sample_t in_data,
  output logic    lp_valid,
  output sample_t lp_data,
  output sample_t filt,
  output sample_t dly3
);
  localparam int HIST = 3;

  sample_t hist [HIST];
  logic    phase;
  logic    emit;

  assign filt = lp3(in_data, hist[0], hist[1]);
  assign dly3 = hist[HIST-1];
  assign emit = in_valid && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
      phase    <= 1'b0;
      lp_valid <= 1'b0;
      lp_data  <= '0;
    end else if (clr) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
      phase    <= 1'b0;
      lp_valid <= 1'b0;
      lp_data  <= '0;
    end else begin
      lp_valid <= emit;
      if (in_valid) begin
        hist[0] <= in_data;
        for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
        phase <= ~phase;
      end
      if (emit) lp_data <= filt;
    end
  end

  // R2: decimated strobes never land on adjacent cycles
  a_r2_decim_gap: assert property (@(posedge clk) disable iff (!rst_n)
    lp_valid |=> !lp_valid);

  // R9: no low-pass strobe without an accepted sample one cycle earlier
  a_r9_lp_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || clr) |=> !lp_valid);
endmodule

// File: rtl/osf_bandpass.sv
module osf_bandpass
  import osf_pkg::*;
#(
  parameter int unsigned COEF_FRAC = 4,
  parameter int unsigned TAP_SH [4] = '{4, 3, 2, 1},
  parameter logic [3:0]  TAP_NEG = 4'b0101
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    in_valid,
  input  sample_t filt,
  input  sample_t dly3,
  output logic    bp_valid,
  output sample_t bp_data,
  output sample_t bp_next
);
  localparam int NTAP = 7;
  localparam int HALF = (NTAP + 1) / 2;

  diff_t d_new;
  diff_t dh [NTAP-1];
  diff_t w  [NTAP];
  acc_t  term [NTAP];
  acc_t  sum;

  assign d_new = {{(DW-SW){dly3[SW-1]}}, dly3} - {{(DW-SW){filt[SW-1]}}, filt};
  assign w[0]  = d_new;

  for (genvar k = 1; k < NTAP; k++) begin : g_win
    assign w[k] = dh[k-1];
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    localparam int M  = (k < HALF) ? k : NTAP - 1 - k;
    localparam int UP = COEF_FRAC - TAP_SH[M];
    acc_t wext;
    assign wext = acc_t'(w[k]);
    if (TAP_NEG[M]) begin : g_neg
      assign term[k] = -(wext <<< UP);
    end else begin : g_pos
      assign term[k] = wext <<< UP;
    end
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NTAP; k++) sum = sum + term[k];
  end

  assign bp_next = sat_round(sum, COEF_FRAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP-1; i++) dh[i] <= '0;
      bp_valid <= 1'b0;
      bp_data  <= '0;
    end else if (clr) begin
      for (int i = 0; i < NTAP-1; i++) dh[i] <= '0;
      bp_valid <= 1'b0;
      bp_data  <= '0;
    end else begin
      bp_valid <= in_valid;
      if (in_valid) begin
        dh[0] <= d_new;
        for (int i = 1; i < NTAP-1; i++) dh[i] <= dh[i-1];
        bp_data <= bp_next;
      end
    end
  end

  // R4: one band-pass strobe per accepted sample
  a_r4_bp_per_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> bp_valid);

  // R9: idle or cleared cycles raise no band-pass strobe
  a_r9_bp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || clr) |=> !bp_valid);

  // R9: registered band value holds while no sample arrives
  a_r9_bp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(bp_data));
endmodule

// File: rtl/osf_power.sv
module osf_power
  import osf_pkg::*;
#(
  parameter int unsigned LOG2_MIN = 2,
  parameter int unsigned LOG2_MAX = 8,
  localparam int NSEL_W = $clog2(LOG2_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_valid,
  input  sample_t           smp,
  input  logic [NSEL_W-1:0] avg_log2,
  output logic              pwr_valid,
  output logic [SW-1:0]     pwr_data
);
  localparam int CNT_W  = LOG2_MAX;
  localparam int PACC_W = SW + 1 + LOG2_MAX;
  localparam logic [NSEL_W-1:0] N_MIN = NSEL_W'(LOG2_MIN);
  localparam logic [NSEL_W-1:0] N_MAX = NSEL_W'(LOG2_MAX);

  logic [CNT_W-1:0]  cnt;
  logic [NSEL_W-1:0] n_q, n_in, n_eff;
  logic [PACC_W-1:0] acc, acc_next;
  logic [CNT_W:0]    cnt_p1, win;
  logic              last;

  assign n_in     = (avg_log2 < N_MIN) ? N_MIN : (avg_log2 > N_MAX) ? N_MAX : avg_log2;
  assign n_eff    = (cnt == '0) ? n_in : n_q;
  assign cnt_p1   = {1'b0, cnt} + 1'b1;
  assign win      = (CNT_W+1)'(1) << n_eff;
  assign last     = (cnt_p1 == win);
  assign acc_next = acc + {{(PACC_W-SW-1){1'b0}}, mag(smp)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; acc <= '0; n_q <= N_MIN;
      pwr_valid <= 1'b0; pwr_data <= '0;
    end else if (clr) begin
      cnt <= '0; acc <= '0; n_q <= N_MIN;
      pwr_valid <= 1'b0; pwr_data <= '0;
    end else begin
      pwr_valid <= smp_valid && last;
      if (smp_valid) begin
        n_q <= n_eff;
        if (last) begin
          pwr_data <= SW'(acc_next >> n_eff);
          acc      <= '0;
          cnt      <= '0;
        end else begin
          acc <= acc_next;
          cnt <= cnt_p1[CNT_W-1:0];
        end
      end
    end
  end

  // R6: mean magnitude never exceeds full scale
  a_r6_pwr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |-> (pwr_data <= SW'(2 ** (SW - 1))));

  // R7: latched exponent stays inside the clamp range
  a_r7_n_range: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q >= N_MIN) && (n_q <= N_MAX));

  // R8: a running window never outgrows its latched length
  a_r8_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ({1'b0, cnt} < ((CNT_W+1)'(1) << n_q)));
endmodule

// File: rtl/octave_split_stage.sv
module octave_split_stage
  import osf_pkg::*;
#(
  parameter int unsigned COEF_FRAC = 4,
  parameter int unsigned TAP_SH [4] = '{4, 3, 2, 1},
  parameter logic [3:0]  TAP_NEG = 4'b0101,
  parameter int unsigned LOG2_MIN = 2,
  parameter int unsigned LOG2_MAX = 8,
  localparam int NSEL_W = $clog2(LOG2_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [SW-1:0]     in_data,
  input  logic [NSEL_W-1:0] avg_log2,
  output logic              lp_valid,
  output logic [SW-1:0]     lp_data,
  output logic              bp_valid,
  output logic [SW-1:0]     bp_data,
  output logic              pwr_valid,
  output logic [SW-1:0]     pwr_data
);
  sample_t x_in, filt, dly3, lp_s, bp_s, bp_next;
  logic    take;

  assign x_in    = sample_t'(in_data);
  assign take    = in_valid && !clr;
  assign lp_data = lp_s;
  assign bp_data = bp_s;

  osf_lowpass u_lp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(x_in),
    .lp_valid(lp_valid), .lp_data(lp_s), .filt(filt), .dly3(dly3)
  );

  osf_bandpass #(.COEF_FRAC(COEF_FRAC), .TAP_SH(TAP_SH), .TAP_NEG(TAP_NEG)) u_bp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .filt(filt),
    .dly3(dly3), .bp_valid(bp_valid), .bp_data(bp_s), .bp_next(bp_next)
  );

  osf_power #(.LOG2_MIN(LOG2_MIN), .LOG2_MAX(LOG2_MAX)) u_pw (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(take), .smp(bp_next),
    .avg_log2(avg_log2), .pwr_valid(pwr_valid), .pwr_data(pwr_data)
  );

  // R6: a power result closes a window on a band-pass sample
  a_r6_pwr_with_bp: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_valid |-> bp_valid);

  // R1: clear leaves every strobe low next cycle
  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!lp_valid && !bp_valid && !pwr_valid));
endmodule

// File: tb/test_octave_split_stage.sv
`timescale 1ns/1ps
module test_octave_split_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [3:0] avg_log2 = 4'd2;
  logic lp_valid, bp_valid, pwr_valid;
  logic [15:0] lp_data, bp_data, pwr_data;

  always #2 clk = ~clk;

  octave_split_stage i_octave_split_stage (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .avg_log2(avg_log2), .lp_valid(lp_valid), .lp_data(lp_data),
    .bp_valid(bp_valid), .bp_data(bp_data), .pwr_valid(pwr_valid), .pwr_data(pwr_data)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam int NV = 16;
  localparam int STIM_X   [NV] = '{1200, -800, 30000, -30000, 5, 0, -1, 7777,
                                   -12345, 22222, 100, -100, 32767, -32768, 16000, -4};
  localparam int STIM_GAP [NV] = '{0, 0, 1, 0, 3, 0, 0, 2, 0, 1, 0, 0, 0, 0, 4, 0};
  localparam int CNUM [7] = '{-1, 2, -4, 8, -4, 2, -1};

  // reference state
  int mx [3];
  int md [6];
  bit mph;
  int pacc, pcnt, pn;
  bit e_lpv, e_pwv;
  int e_lp, e_bp, e_pw;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) mx[i] = 0;
    for (int i = 0; i < 6; i++) md[i] = 0;
    mph = 0; pacc = 0; pcnt = 0; pn = 2;
  endtask

  task automatic model_step(input int x);
    int f, d, s, bp, a;
    f = (x + 2 * mx[0] + mx[1] + 2) >>> 2;
    d = mx[2] - f;
    s = CNUM[0] * d;
    for (int k = 1; k < 7; k++) s += CNUM[k] * md[k-1];
    bp = (s + 8) >>> 4;
    if (bp > 32767) bp = 32767;
    if (bp < -32768) bp = -32768;
    e_lpv = mph;
    if (mph) e_lp = f;
    mph = !mph;
    mx[2] = mx[1]; mx[1] = mx[0]; mx[0] = x;
    for (int k = 5; k > 0; k--) md[k] = md[k-1];
    md[0] = d;
    e_bp = bp;
    if (pcnt == 0) pn = (avg_log2 < 2) ? 2 : (avg_log2 > 8) ? 8 : int'(avg_log2);
    a = (bp < 0) ? -bp : bp;
    pacc += a;
    pcnt++;
    e_pwv = (pcnt == (1 << pn));
    if (e_pwv) begin
      e_pw = pacc >> pn;
      pacc = 0;
      pcnt = 0;
    end
  endtask

  task automatic send(input int x);
    in_valid = 1'b1;
    in_data = x[15:0];
    model_step(x);
    @(negedge clk);
    in_valid = 1'b0;
    chk(lp_valid == e_lpv, "R2", "lp_valid", int'(lp_valid), int'(e_lpv));
    if (e_lpv) chk($signed(lp_data) == e_lp, "R2", "lp_data", $signed(lp_data), e_lp);
    chk(bp_valid == 1'b1, "R4", "bp_valid", int'(bp_valid), 1);
    chk($signed(bp_data) == e_bp, "R4", "bp_data", $signed(bp_data), e_bp);
    chk(pwr_valid == e_pwv, "R6", "pwr_valid", int'(pwr_valid), int'(e_pwv));
    if (e_pwv) chk(int'(pwr_data) == e_pw, "R6", "pwr_data", int'(pwr_data), e_pw);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!lp_valid && !bp_valid && !pwr_valid, "R9", "strobes while idle",
          int'({lp_valid, bp_valid, pwr_valid}), 0);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    in_valid = 1'b1;
    in_data = 16'd1234;
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
    model_reset();
    chk(!lp_valid && !bp_valid && !pwr_valid, "R1", "strobes after clear",
        int'({lp_valid, bp_valid, pwr_valid}), 0);
    chk(lp_data == 0 && bp_data == 0 && pwr_data == 0, "R1", "data after clear",
        int'(lp_data) + int'(bp_data) + int'(pwr_data), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual %0d expected %0d cycles", 200000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int lp_keep, npw, at;
    bit sat_seen;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!lp_valid && !bp_valid && !pwr_valid, "R1", "strobes in reset",
        int'({lp_valid, bp_valid, pwr_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lp_data == 0 && bp_data == 0 && pwr_data == 0, "R1", "data after reset",
        int'(lp_data) + int'(bp_data) + int'(pwr_data), 0);

    // hand-worked first samples: f=250, d=-250, bp=16; then lp=750
    send(1000);
    chk($signed(bp_data) == 16, "R3", "first band value", $signed(bp_data), 16);
    chk(!lp_valid, "R2", "no lp on first sample", int'(lp_valid), 0);
    send(1000);
    chk(lp_valid && $signed(lp_data) == 750, "R2", "second sample lp", $signed(lp_data), 750);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(STIM_X[i]);
      if (STIM_GAP[i] > 0) idle(STIM_GAP[i]);
    end

    // R9: idle keeps lp_data and history
    lp_keep = int'(lp_data);
    idle(5);
    chk(int'(lp_data) == lp_keep, "R9", "lp_data held", int'(lp_data), lp_keep);
    send(-2500);

    // R1: clear restarts phase and history; f=125, d=-125, bp=8
    do_clear();
    send(500);
    chk(!lp_valid, "R1", "phase restart", int'(lp_valid), 0);
    chk($signed(bp_data) == 8, "R1", "zero history band", $signed(bp_data), 8);

    // R5: alternating full-scale input drives the band output into saturation
    avg_log2 = 4'd3;
    sat_seen = 0;
    for (int i = 0; i < 16; i++) begin
      send((i % 2 == 0) ? 32767 : -32768);
      if ($signed(bp_data) == 32767 || $signed(bp_data) == -32768) sat_seen = 1;
    end
    chk(sat_seen, "R5", "saturated band value seen", int'(sat_seen), 1);

    // R7: low clamp gives windows of 4
    do_clear();
    avg_log2 = 4'd0;
    npw = 0;
    for (int i = 0; i < 8; i++) begin
      send(3000 - 700 * i);
      if (pwr_valid) npw++;
    end
    chk(npw == 2, "R7", "windows of 4 from N=0", npw, 2);

    // R7: high clamp gives a window of 256
    do_clear();
    avg_log2 = 4'd15;
    npw = 0; at = -1;
    for (int i = 0; i < 256; i++) begin
      send(((i * 37) % 200 - 100) * 150);
      if (pwr_valid) begin npw++; at = i; end
    end
    chk(npw == 1 && at == 255, "R7", "single window of 256 from N=15", at, 255);

    // R8: change in mid window has no effect until the next window
    do_clear();
    avg_log2 = 4'd2;
    send(4000);
    avg_log2 = 4'd5;
    send(-4000);
    send(2000);
    send(-1000);
    chk(pwr_valid, "R8", "window kept at 4", int'(pwr_valid), 1);
    npw = 0; at = -1;
    for (int i = 0; i < 32; i++) begin
      send(i * 100 - 1600);
      if (pwr_valid) begin npw++; at = i; end
    end
    chk(npw == 1 && at == 31, "R8", "next window 32", at, 31);
    idle(2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule